// File: doc/BRIEF.md
# Programmable Modulator Clock Generator

This block derives a clock for an external sigma-delta modulator from the system clock. An integer divider of 1 to 63 sets the output period in system-clock cycles. Each period starts with its high phase and ends with its low phase. A new divider value is picked up only when a period ends, so a period is never cut short.

A two-bit mode input selects the start behaviour. The clock can stay off, start at once, or wait for a rising edge on an asynchronous PWM sync input and then run freely. Starting on that edge places the modulator clock in a known relation to PWM timing. To move the phase later, software pulses a request strobe. The request sets a busy flag. The period after the one in progress then gets extra low cycles, as many as the adjust input gives. When that longer period ends, the hardware clears the busy flag.

Top module: `modclk_gen`

## Requirements
- R1: While reset is applied and in the first cycle after it, `mod_clk`, `running` and `adj_busy` are all 0.
- R2: The mode codes are 0 = off, 1 = off (reserved), 2 = start now, 3 = start on the next sync rising edge. With code 2 set before a clock edge, `running` and `mod_clk` are 1 after that edge. With code 0 or 1 set before an edge, `mod_clk` and `running` are 0 after that edge. A later restart begins a fresh period.
- R3: For a divider N from 2 to 63, every period is N cycles long, with floor(N/2) cycles high followed by the remaining cycles low.
- R4: With a divider of 1, `mod_clk` stays high while running. A divider value of 0 behaves as 1.
- R5: A divider change made during a period does not alter that period. The new value applies from the next period.
- R6: In mode 3 the clock does not start while the sync input is held at a steady level. After sync goes from 0 to 1, `running` and `mod_clk` are still 0 after two clock edges and become 1 after the third.
- R7: A one-cycle pulse on `req_set` while the mode is 2 or 3 makes `adj_busy` 1 after the next edge. The period that follows the one in progress has the same high time as usual and a low time extended by `cfg_adj` cycles. Only that one period is extended.
- R8: `adj_busy` falls at the end of the extended period. While it is 1, pulses on `req_set` are ignored and cause no further extension.
- R9: Sync edges that arrive while the clock is running do not change the output period or phase.
- R10: Selecting mode 0 or 1 clears a pending request. `req_set` pulses given while the mode is 0 or 1 are ignored, so after a restart every period has the normal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Start mode: 0/1 off, 2 start now, 3 start on sync edge |
| cfg_div | input | 6 | Period length in system-clock cycles (1..63) |
| cfg_adj | input | 6 | Extra low cycles for one requested period (1..63) |
| req_set | input | 1 | One-cycle strobe that requests a phase adjust |
| pwm_sync | input | 1 | Asynchronous PWM sync input |
| mod_clk | output | 1 | Modulator clock |
| running | output | 1 | The clock is running |
| adj_busy | output | 1 | An adjust request is pending or in progress |

## Verification
The assertions assume that `cfg_mode` and `req_set` change synchronously to `clk`. They also assume that `req_set` is a strobe whose effect shows one edge later. They make no assumption about when `pwm_sync` toggles. The bench drives every input at the falling clock edge. It keeps the divider and adjust values within 1 to 63, except for one directed case that uses a divider of 0. It gives each request as a single-cycle pulse, so every rise of `adj_busy` follows a sampled strobe.

// File: rtl/modclk_pkg.sv
package modclk_pkg;

  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_RSVD = 2'd1;
  localparam logic [1:0] MODE_NOW  = 2'd2;
  localparam logic [1:0] MODE_SYNC = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } run_state_t;

  // High-phase length for a period of n cycles; n of 0 or 1 counts as 1.
  function automatic int unsigned high_cycles(input int unsigned n);
    return (n <= 1) ? 1 : (n / 2);
  endfunction

endpackage

// File: rtl/modclk_sync.sv
module modclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/modclk_ctrl.sv
module modclk_ctrl
  import modclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cfg_mode,
  input  logic       sync_rise,
  output logic       en,
  output logic       start,
  output logic       run_q,
  output logic       run_d
);
  run_state_t state_q, state_n;

  assign en = cfg_mode[1];

  always_comb begin
    state_n = state_q;
    if (!en) begin
      state_n = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_WAIT: begin
          if (cfg_mode == MODE_NOW || (cfg_mode == MODE_SYNC && sync_rise))
            state_n = ST_RUN;
          else
            state_n = ST_WAIT;
        end
        ST_RUN:  state_n = ST_RUN;
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_n;
  end

  assign run_q = (state_q == ST_RUN);
  assign run_d = (state_n == ST_RUN);
  assign start = run_d && !run_q;
endmodule

// File: rtl/modclk_divider.sv
module modclk_divider
  import modclk_pkg::*;
#(
  parameter int DIV_W = 6,
  parameter int ADJ_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             run_q,
  input  logic             run_d,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [ADJ_W-1:0] cfg_adj,
  input  logic             req_set,
  output logic             mod_clk,
  output logic             busy
);
  localparam int CNT_W = ((DIV_W > ADJ_W) ? DIV_W : ADJ_W) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DIV_W-1:0] div_q, div_n, div_in;
  logic [ADJ_W-1:0] ext_q, ext_n, adj_in;
  logic             inadj_q, inadj_n;
  logic             busy_q, busy_n;
  logic             mod_q, mod_n;
  logic [CNT_W-1:0] len;
  logic             last;

  assign div_in = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
  assign adj_in = (cfg_adj == '0) ? ADJ_W'(1) : cfg_adj;
  assign len    = CNT_W'(div_q) + CNT_W'(ext_q);
  assign last   = (cnt_q == len - CNT_W'(1));

  always_comb begin
    cnt_n   = cnt_q;
    div_n   = div_q;
    ext_n   = ext_q;
    inadj_n = inadj_q;
    busy_n  = busy_q;
    if (!en) begin
      cnt_n   = '0;
      ext_n   = '0;
      inadj_n = 1'b0;
      busy_n  = 1'b0;
    end else begin
      if (req_set && !busy_q) busy_n = 1'b1;
      if (start) begin
        cnt_n   = '0;
        div_n   = div_in;
        ext_n   = '0;
        inadj_n = 1'b0;
      end else if (run_q) begin
        if (last) begin
          cnt_n = '0;
          div_n = div_in;
          if (inadj_q) begin
            inadj_n = 1'b0;
            ext_n   = '0;
            busy_n  = 1'b0;
          end else if (busy_q) begin
            inadj_n = 1'b1;
            ext_n   = adj_in;
          end else begin
            ext_n   = '0;
          end
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
    end
    mod_n = run_d && (cnt_n < CNT_W'(high_cycles(32'(div_n))));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      div_q   <= DIV_W'(1);
      ext_q   <= '0;
      inadj_q <= 1'b0;
      busy_q  <= 1'b0;
      mod_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      div_q   <= div_n;
      ext_q   <= ext_n;
      inadj_q <= inadj_n;
      busy_q  <= busy_n;
      mod_q   <= mod_n;
    end
  end

  assign mod_clk = mod_q;
  assign busy    = busy_q;
endmodule

// File: rtl/modclk_gen.sv
module modclk_gen #(
  parameter int DIV_W       = 6,
  parameter int ADJ_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [ADJ_W-1:0] cfg_adj,
  input  logic             req_set,
  input  logic             pwm_sync,
  output logic             mod_clk,
  output logic             running,
  output logic             adj_busy
);
  logic sync_rise, en, start, run_q, run_d;

  modclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pwm_sync), .rise(sync_rise)
  );

  modclk_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .sync_rise(sync_rise),
    .en(en), .start(start), .run_q(run_q), .run_d(run_d)
  );

  modclk_divider #(.DIV_W(DIV_W), .ADJ_W(ADJ_W)) u_div (
    .clk(clk), .rst(rst), .en(en), .start(start), .run_q(run_q),
    .run_d(run_d), .cfg_div(cfg_div), .cfg_adj(cfg_adj),
    .req_set(req_set), .mod_clk(mod_clk), .busy(adj_busy)
  );

  assign running = run_q;
endmodule

// File: rtl/modclk_chk.sv
module modclk_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_mode,
  input logic       req_set,
  input logic       mod_clk,
  input logic       running,
  input logic       adj_busy
);
  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode[1] |=> (!mod_clk && !running));

  p_start_mode_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(cfg_mode[1]));

  p_busy_src_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(adj_busy) |-> ($past(req_set) && $past(cfg_mode[1])));

  p_clear_hw_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(adj_busy) |-> ($past(running) || !$past(cfg_mode[1])));

  p_off_clear_r10: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode[1] |=> !adj_busy);
endmodule

bind modclk_gen modclk_chk u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .req_set(req_set),
  .mod_clk(mod_clk), .running(running), .adj_busy(adj_busy)
);

// File: tb/tb_modclk_gen.sv
module tb_modclk_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_mode = 2'd0;
  logic [5:0] cfg_div = 6'd8;
  logic [5:0] cfg_adj = 6'd1;
  logic       req_set = 1'b0;
  logic       pwm_sync = 1'b0;
  logic       mod_clk, running, adj_busy;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  modclk_gen dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_div(cfg_div),
    .cfg_adj(cfg_adj), .req_set(req_set), .pwm_sync(pwm_sync),
    .mod_clk(mod_clk), .running(running), .adj_busy(adj_busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic align();
    int prev = int'(mod_clk);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (prev == 0 && mod_clk) break;
      prev = int'(mod_clk);
    end
  endtask

  // Counts from a point where h0 high samples of this period are already seen.
  task automatic measure(input int h0, output int h, output int l);
    h = h0;
    l = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (mod_clk) h++; else break;
    end
    l = 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!mod_clk) l++; else break;
    end
  endtask

  task automatic go_off();
    cfg_mode = 2'd0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 mod_clk", int'(mod_clk), 0);
    check("R1 running", int'(running), 0);
    check("R1 adj_busy", int'(adj_busy), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mod_clk after release", int'(mod_clk), 0);
  endtask

  task automatic t_start_now();
    int h, l;
    cfg_div  = 6'd8;
    cfg_mode = 2'd2;
    @(negedge clk);
    check("R2 running at start", int'(running), 1);
    check("R2 mod_clk at start", int'(mod_clk), 1);
    measure(1, h, l);
    check("R3 high N=8", h, 4);
    check("R3 low N=8", l, 4);
  endtask

  task automatic t_duty(input int n);
    int h, l;
    go_off();
    cfg_div  = 6'(n);
    cfg_mode = 2'd2;
    align();
    measure(1, h, l);
    check("R3 high", h, n / 2);
    check("R3 low", l, n - n / 2);
  endtask

  task automatic t_div_one(input int d);
    int highs = 0;
    go_off();
    cfg_div  = 6'(d);
    cfg_mode = 2'd2;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      highs += int'(mod_clk);
      @(negedge clk);
    end
    check("R4 steady high samples", highs, 20);
  endtask

  task automatic t_div_change();
    int h, l;
    go_off();
    cfg_div  = 6'd8;
    cfg_mode = 2'd2;
    align();
    cfg_div = 6'd4;
    measure(1, h, l);
    check("R5 old period high", h, 4);
    check("R5 old period low", l, 4);
    measure(1, h, l);
    check("R5 new period high", h, 2);
    check("R5 new period low", l, 2);
  endtask

  task automatic t_stop(input logic [1:0] off_code);
    int h, l;
    go_off();
    cfg_div  = 6'd8;
    cfg_mode = 2'd2;
    align();
    cfg_mode = off_code;
    @(negedge clk);
    check("R2 stop mod_clk", int'(mod_clk), 0);
    check("R2 stop running", int'(running), 0);
    cfg_mode = 2'd2;
    @(negedge clk);
    check("R2 restart mod_clk", int'(mod_clk), 1);
    measure(1, h, l);
    check("R2 fresh period high", h, 4);
    check("R2 fresh period low", l, 4);
  endtask

  task automatic t_sync_start();
    int h, l;
    go_off();
    pwm_sync = 1'b1;
    cfg_div  = 6'd8;
    repeat (4) @(negedge clk);
    cfg_mode = 2'd3;
    repeat (30) @(negedge clk);
    check("R6 level ignored running", int'(running), 0);
    check("R6 level ignored mod_clk", int'(mod_clk), 0);
    pwm_sync = 1'b0;
    repeat (4) @(negedge clk);
    pwm_sync = 1'b1;
    @(negedge clk);
    check("R6 after 1 edge", int'(running), 0);
    @(negedge clk);
    check("R6 after 2 edges", int'(running), 0);
    @(negedge clk);
    check("R6 after 3 edges running", int'(running), 1);
    check("R6 after 3 edges mod_clk", int'(mod_clk), 1);
    pwm_sync = 1'b0;
    @(negedge clk);
    @(negedge clk);
    pwm_sync = 1'b1;
    measure(3, h, l);
    check("R9 high with sync edge", h, 4);
    check("R9 low with sync edge", l, 4);
    measure(1, h, l);
    check("R9 next high", h, 4);
    check("R9 next low", l, 4);
  endtask

  task automatic t_adjust(input bit retrigger);
    int h, l;
    go_off();
    cfg_div  = 6'd6;
    cfg_adj  = 6'd5;
    cfg_mode = 2'd2;
    align();
    req_set = 1'b1;
    @(negedge clk);
    req_set = 1'b0;
    check("R7 busy set", int'(adj_busy), 1);
    measure(2, h, l);
    check("R7 current period high", h, 3);
    check("R7 current period low", l, 3);
    check("R7 busy at extended start", int'(adj_busy), 1);
    if (retrigger) begin
      req_set = 1'b1;
      @(negedge clk);
      req_set = 1'b0;
      measure(2, h, l);
    end else begin
      measure(1, h, l);
    end
    check("R7 extended high", h, 3);
    check("R7 extended low", l, 8);
    check("R8 busy cleared", int'(adj_busy), 0);
    measure(1, h, l);
    check("R8 following high", h, 3);
    check("R8 following low", l, 3);
  endtask

  task automatic t_disable_clears();
    int h, l;
    go_off();
    cfg_div  = 6'd6;
    cfg_adj  = 6'd5;
    cfg_mode = 2'd2;
    align();
    req_set = 1'b1;
    @(negedge clk);
    req_set = 1'b0;
    check("R10 busy before off", int'(adj_busy), 1);
    cfg_mode = 2'd1;
    @(negedge clk);
    check("R10 busy cleared by off", int'(adj_busy), 0);
    req_set = 1'b1;
    @(negedge clk);
    req_set = 1'b0;
    @(negedge clk);
    check("R10 request ignored while off", int'(adj_busy), 0);
    cfg_mode = 2'd2;
    @(negedge clk);
    measure(1, h, l);
    check("R10 first low", l, 3);
    measure(1, h, l);
    check("R10 second low", l, 3);
    measure(1, h, l);
    check("R10 third low", l, 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_start_now();
    t_duty(7);
    t_duty(2);
    t_duty(63);
    t_div_one(1);
    t_div_one(0);
    t_div_change();
    t_stop(2'd0);
    t_stop(2'd1);
    t_sync_start();
    t_adjust(1'b0);
    t_adjust(1'b1);
    t_disable_clears();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule